// File: doc/BRIEF.md
# Synthesizer Fast-Acquisition Gain Controller

This controller runs a temporary high-gain acquisition phase for a frequency synthesizer. A register front end presents an enable bit, a divider-quarter select, an exit-method select, a 6-bit timeout and a GO write port. While the high-gain state is held, the controller raises the charge-pump current select to 4x and drives the acquisition pin low. It can also ask the reference (R) and feedback (N) counters to run at one quarter of their programmed ratios. Together with the 4x current, this raises the loop gain sixteenfold.

A single-cycle strobe from the phase detector, one per reference cycle, serves as the time base. The high-gain state is only ever left on one of these strobes, so the loop filter sees a seamless hand-over. In the timed modes a down-counter measures the phase in strobes and then clears GO by itself, and the GO readback shows that clear. In the manual modes the state lasts until the host writes GO back to 0. The mode bits and the timeout are captured at the moment GO goes from 0 to 1.

Top module: `fastlock_ctrl`

## Requirements
- R1: After an active-low reset, go_rd is 0, cp_gain_4x is 0, fl_oe is 0 (pin released) and div_quarter is 0.
- R2: While cfg_enable is 0, a GO write is ignored: go_rd stays 0 and all outputs stay at normal values. Dropping cfg_enable during high gain returns everything to normal at the next clock edge.
- R3: High gain (cp_gain_4x=1, fl_oe=1, fl_out=0) is entered only after a GO write of 1 with cfg_enable=1. go_rd rises at the write edge and the outputs follow one clock later.
- R4: In normal operation cp_gain_4x=0 (1x current), fl_oe=0 and div_quarter=0. The fl_out level is always 0, so the pin is low whenever it is driven.
- R5: div_quarter is 1 exactly while high gain is held, if cfg_quarter was 1 when GO rose.
- R6: With cfg_timed=1 when GO rose and a timeout of N (0..63), the Nth+1 pd_tick after the write clears go_rd and ends high gain at that same edge. Each earlier tick leaves both unchanged.
- R7: With cfg_timed=0, high gain persists across any number of pd_tick pulses for as long as GO stays 1.
- R8: High gain only ends at a clock edge where pd_tick is 1, unless cfg_enable is 0.
- R9: A timeout of 0 ends high gain on the first pd_tick after the GO write.
- R10: A host write of GO=0 clears go_rd at once. High gain ends on the next pd_tick.
- R11: The counter is loaded from cfg_timeout only when GO goes from 0 to 1. A GO write of 1 while GO is already 1 does not restart the count.
- R12: When a GO write lands in the same cycle as timeout expiry, the expiry wins: go_rd becomes 0 and high gain ends.
- R13: go_rd always reflects the automatic clear performed by the timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_enable | input | 1 | Fast acquisition enable |
| cfg_quarter | input | 1 | Quarter the R and N ratios during high gain |
| cfg_timed | input | 1 | 1: timeout exit, 0: manual exit |
| cfg_timeout | input | 6 | Timeout in phase-detector cycles |
| go_wr | input | 1 | GO write strobe |
| go_wdata | input | 1 | GO write value |
| pd_tick | input | 1 | One-cycle strobe per phase-detector cycle |
| go_rd | output | 1 | GO readback |
| cp_gain_4x | output | 1 | Charge-pump current select, 1 = 4x |
| fl_out | output | 1 | Acquisition pin level (always low) |
| fl_oe | output | 1 | Acquisition pin drive enable, 0 = high impedance |
| div_quarter | output | 1 | Divider quarter request for R and N counters |

## Verification
Two functions can fall in the same cycle: the timeout's automatic clear of GO and a host write to GO. The bench provokes this by asserting a GO write of 1 together with the pd_tick that exhausts a zero timeout. On the following cycle it expects go_rd=0 and normal outputs, and it checks that a later tick causes no re-entry. The non-restart rule is judged the same way: a GO write of 1 in the middle of a timed run must not lengthen it beyond N+1 ticks.

// File: rtl/fastlock_pkg.sv
package fastlock_pkg;

    localparam int unsigned FL_CNT_W = 6;

    typedef struct packed {
        logic go;
        logic timed;
        logic quart;
    } go_state_t;

    typedef struct packed {
        logic hg;
        logic div;
    } gain_state_t;

endpackage

// File: rtl/fastlock_goreg.sv
module fastlock_goreg
    import fastlock_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic go_wr,
    input  logic go_wdata,
    input  logic cfg_timed,
    input  logic cfg_quarter,
    input  logic expire,
    output logic go_q,
    output logic timed_q,
    output logic quart_q,
    output logic load
);

    go_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        load = 1'b0;
        if (!enable) begin
            st_d.go = 1'b0;
        end else if (expire) begin
            st_d.go = 1'b0;                 // expiry beats a concurrent write
        end else if (go_wr) begin
            st_d.go = go_wdata;
            if (go_wdata && !st_q.go) begin
                load        = 1'b1;
                st_d.timed  = cfg_timed;
                st_d.quart  = cfg_quarter;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign go_q    = st_q.go;
    assign timed_q = st_q.timed;
    assign quart_q = st_q.quart;

    p_go_rises_on_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.go) |-> $past(go_wr && go_wdata && enable));

    p_disabled_no_go_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !st_q.go);

    p_expire_clears_go_r13: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> !st_q.go);

endmodule

// File: rtl/fastlock_timer.sv
module fastlock_timer #(
    parameter int unsigned CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             run,
    input  logic             tick,
    output logic             expire
);

    localparam logic [CNT_W-1:0] ZERO = '0;

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        expire = run && tick && (cnt_q == ZERO);
        cnt_d  = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (run && tick && (cnt_q != ZERO)) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    p_count_only_down_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> (cnt_q <= $past(cnt_q)));

    p_count_moves_on_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !tick) |=> $stable(cnt_q));

endmodule

// File: rtl/fastlock_gain.sv
module fastlock_gain
    import fastlock_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic go_q,
    input  logic expire,
    input  logic tick,
    input  logic quart_sel,
    output logic hg_q,
    output logic div_q
);

    gain_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!enable) begin
            st_d.hg = 1'b0;
        end else if (tick && (expire || !go_q)) begin
            st_d.hg = 1'b0;                 // leave only on a detector cycle
        end else if (go_q) begin
            st_d.hg = 1'b1;
        end
        st_d.div = st_d.hg && quart_sel;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hg_q  = st_q.hg;
    assign div_q = st_q.div;

    p_exit_on_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.hg) |-> $past(tick || !enable));

    p_manual_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && go_q && !expire) |=> st_q.hg);

    p_entry_needs_go_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.hg) |-> $past(go_q));

    p_disabled_normal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !st_q.hg);

endmodule

// File: rtl/fastlock_ctrl.sv
module fastlock_ctrl #(
    parameter int unsigned CNT_W = fastlock_pkg::FL_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_enable,
    input  logic             cfg_quarter,
    input  logic             cfg_timed,
    input  logic [CNT_W-1:0] cfg_timeout,
    input  logic             go_wr,
    input  logic             go_wdata,
    input  logic             pd_tick,
    output logic             go_rd,
    output logic             cp_gain_4x,
    output logic             fl_out,
    output logic             fl_oe,
    output logic             div_quarter
);

    logic go_q, timed_q, quart_q, load, expire, hg_q, div_q;

    fastlock_goreg u_goreg (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (cfg_enable),
        .go_wr      (go_wr),
        .go_wdata   (go_wdata),
        .cfg_timed  (cfg_timed),
        .cfg_quarter(cfg_quarter),
        .expire     (expire),
        .go_q       (go_q),
        .timed_q    (timed_q),
        .quart_q    (quart_q),
        .load       (load)
    );

    fastlock_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (cfg_timeout),
        .run      (go_q && timed_q),
        .tick     (pd_tick),
        .expire   (expire)
    );

    fastlock_gain u_gain (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (cfg_enable),
        .go_q      (go_q),
        .expire    (expire),
        .tick      (pd_tick),
        .quart_sel (quart_q),
        .hg_q      (hg_q),
        .div_q     (div_q)
    );

    assign go_rd       = go_q;
    assign cp_gain_4x  = hg_q;
    assign fl_oe       = hg_q;
    assign fl_out      = 1'b0;
    assign div_quarter = div_q;

    p_div_only_in_hg_r5: assert property (@(posedge clk) disable iff (!rst_n)
        div_quarter |-> cp_gain_4x);

    p_write_loses_to_expiry_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && go_wr) |=> (!go_rd && !cp_gain_4x));

endmodule

// File: tb/fastlock_ctrl_bench.sv
module fastlock_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_enable = 1'b0, cfg_quarter = 1'b0, cfg_timed = 1'b0;
    logic [5:0] cfg_timeout = '0;
    logic       go_wr = 1'b0, go_wdata = 1'b0, pd_tick = 1'b0;
    logic       go_rd, cp_gain_4x, fl_out, fl_oe, div_quarter;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    fastlock_ctrl u_fastlock_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_quarter(cfg_quarter),
        .cfg_timed(cfg_timed), .cfg_timeout(cfg_timeout), .go_wr(go_wr),
        .go_wdata(go_wdata), .pd_tick(pd_tick), .go_rd(go_rd),
        .cp_gain_4x(cp_gain_4x), .fl_out(fl_out), .fl_oe(fl_oe),
        .div_quarter(div_quarter)
    );

    // {enable, quarter, timed, timeout[5:0], expected div_quarter}
    localparam int NV = 6;
    localparam logic [9:0] VEC [NV] = '{
        {1'b1, 1'b1, 1'b1, 6'd3,  1'b1},
        {1'b1, 1'b0, 1'b1, 6'd0,  1'b0},
        {1'b1, 1'b0, 1'b1, 6'd63, 1'b0},
        {1'b1, 1'b1, 1'b0, 6'd5,  1'b1},
        {1'b1, 1'b0, 1'b0, 6'd0,  1'b0},
        {1'b0, 1'b1, 1'b1, 6'd2,  1'b0}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // outputs: {go_rd, cp_gain_4x, fl_oe, fl_out, div_quarter}
    function automatic int outs();
        return {go_rd, cp_gain_4x, fl_oe, fl_out, div_quarter};
    endfunction

    task automatic chk_outs(input string req, input logic [4:0] exp);
        chk(outs() == int'(exp), req, outs(), int'(exp));
    endtask

    task automatic write_go(input logic v);
        go_wr = 1'b1; go_wdata = v;
        @(negedge clk);
        go_wr = 1'b0; go_wdata = 1'b0;
    endtask

    task automatic tick();
        pd_tick = 1'b1;
        @(negedge clk);
        pd_tick = 1'b0;
        @(negedge clk);
    endtask

    task automatic setup(input logic en, input logic q, input logic t, input logic [5:0] n);
        cfg_enable = en; cfg_quarter = q; cfg_timed = t; cfg_timeout = n;
    endtask

    initial begin
        @(negedge clk); @(negedge clk);
        chk_outs("R1 reset state", 5'b00000);
        rst_n = 1'b1;
        @(negedge clk);
        chk_outs("R1 after reset release", 5'b00000);

        for (int v = 0; v < NV; v++) begin
            logic en, q, t, ed;
            logic [5:0] n;
            {en, q, t, n, ed} = VEC[v];
            setup(en, q, t, n);
            write_go(1'b1);
            if (!en) begin
                @(negedge clk);
                chk_outs("R2 GO write ignored while disabled", 5'b00000);
                tick();
                chk_outs("R2 disabled stays normal", 5'b00000);
                continue;
            end
            chk(go_rd == 1'b1, "R3 go_rd at write edge", go_rd, 1);
            @(negedge clk);
            chk_outs("R3 R5 high gain outputs", {1'b1, 1'b1, 1'b1, 1'b0, ed});
            if (t) begin
                for (int k = 0; k < int'(n); k++) tick();
                chk_outs("R6 active before last tick", {1'b1, 1'b1, 1'b1, 1'b0, ed});
                tick();
                chk_outs(n == 0 ? "R9 zero timeout exits on first tick" : "R6 R13 exit and GO clear",
                         5'b00000);
            end else begin
                for (int k = 0; k < 7; k++) tick();
                chk_outs("R7 manual holds across ticks", {1'b1, 1'b1, 1'b1, 1'b0, ed});
                write_go(1'b0);
                @(negedge clk);
                chk_outs("R10 R8 GO cleared, gain held until tick", {1'b0, 1'b1, 1'b1, 1'b0, ed});
                tick();
                chk_outs("R4 normal after manual exit", 5'b00000);
            end
        end

        // R11: rewrite of 1 mid-run does not restart the count
        setup(1'b1, 1'b0, 1'b1, 6'd3);
        write_go(1'b1);
        @(negedge clk);
        tick(); tick();
        write_go(1'b1);
        tick();
        chk_outs("R11 still active with one tick left", 5'b11100);
        tick();
        chk_outs("R11 exit after N+1 ticks total", 5'b00000);

        // R10: abort a timed run
        setup(1'b1, 1'b1, 1'b1, 6'd10);
        write_go(1'b1);
        @(negedge clk);
        tick(); tick();
        write_go(1'b0);
        chk_outs("R10 abort clears GO at once", 5'b01101);
        tick();
        chk_outs("R10 abort ends gain on tick", 5'b00000);

        // R12: expiry and GO write collide
        setup(1'b1, 1'b0, 1'b1, 6'd0);
        write_go(1'b1);
        @(negedge clk);
        pd_tick = 1'b1; go_wr = 1'b1; go_wdata = 1'b1;
        @(negedge clk);
        pd_tick = 1'b0; go_wr = 1'b0; go_wdata = 1'b0;
        chk_outs("R12 expiry wins over write", 5'b00000);
        tick();
        chk_outs("R12 no re-entry", 5'b00000);

        // R2: enable dropped during high gain
        setup(1'b1, 1'b1, 1'b0, 6'd0);
        write_go(1'b1);
        @(negedge clk);
        chk_outs("R2 setup active", 5'b11101);
        cfg_enable = 1'b0;
        @(negedge clk);
        chk_outs("R2 enable drop forces normal", 5'b00000);

        // R1: reset during active run
        setup(1'b1, 1'b1, 1'b1, 6'd20);
        write_go(1'b1);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk_outs("R1 reset mid-run", 5'b00000);
        rst_n = 1'b1;

        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (100000) @(posedge clk);
                checks++; fails++;
                $display("FAIL watchdog expired actual=0 expected=1");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule